// File: doc/BRIEF.md
# Normalizing Sequential Integer Divider

This block divides one unsigned integer by another and returns the quotient and the remainder. When a start pulse arrives, two leading-zero counters measure both operands. Two left shifters then move each operand so that its top set bit is at the most significant position. A restoring radix-2 loop resolves one quotient bit per clock from the normalized pair.

The shift between the two leading-zero counts sets the alignment at the end. The quotient is shifted right to take it back to integer weight. The remainder that was captured at the matching step is shifted right by the divisor's leading-zero count.

Every division with a non-zero divisor takes the same number of cycles. A zero divisor is detected in the start cycle and is answered at once with a flag, and no loop runs. The caller pulses start while the block is idle, then waits for the one-cycle done pulse. The outputs stay valid until the next result is written.

Top module: `norm_div`

## Requirements
- R1: After the asynchronous reset, busy_o, done_o and dbz_o are 0 and quo_o and rem_o are all zeros.
- R2: For a non-zero divisor, the completion writes quo_o = floor(dividend / divisor) and rem_o = dividend mod divisor, and clears dbz_o.
- R3: At every completion with a non-zero divisor, rem_o is strictly less than the divisor that was sampled at start.
- R4: With a non-zero divisor, done_o rises on the W-th rising edge after the edge that samples start_i (W+1 edges counting that edge; 33 for W=32). busy_o is high from the edge after start until done_o rises, and busy_o is low while done_o is high.
- R5: A zero divisor makes done_o and dbz_o high on the edge that samples start_i. It sets quo_o to all ones and rem_o to the dividend, and busy_o stays low.
- R6: When the dividend has more leading zeros than the divisor (dividend < divisor, including a zero dividend, whose count is W), the result is quo_o = 0 and rem_o = dividend, still with the latency of R4.
- R7: A start_i pulse while busy_o is high is ignored. The running division finishes with its own operands and its own latency.
- R8: done_o is high for exactly one cycle unless a new zero-divisor start re-arms it. quo_o, rem_o and dbz_o hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a division; sampled only when idle |
| dividend_i | input | W | Unsigned dividend |
| divisor_i | input | W | Unsigned divisor |
| busy_o | output | 1 | Division loop is running |
| done_o | output | 1 | One-cycle pulse when a result is written |
| dbz_o | output | 1 | Last result came from a zero divisor |
| quo_o | output | W | Quotient |
| rem_o | output | W | Remainder |

## Verification
On every cycle, the assertions check these properties:
- the fixed completion latency, counted against the accepted start;
- that the remainder is below the captured divisor;
- that done and busy are exclusive, and that done is a single-cycle pulse;
- that busy is not dropped early;
- the all-ones quotient on a zero divisor;
- that each normalizer leaves its top bit set, and that it reports a count of W for a zero operand.

Only the bench's scenarios can show that the quotient and the remainder are arithmetically right across the operand space. They also show the cases where the dividend is below the divisor, including a zero dividend, and that a start issued mid-run leaves the running result untouched. Finally they show that the results are held after done falls.

// File: rtl/norm_div_pkg.sv
package norm_div_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/div_lzc.sv
module div_lzc #(
  parameter int W = 32
) (
  input  logic [W-1:0]       x_i,
  output logic [$clog2(W):0] cnt_o
);
  localparam int CW = $clog2(W) + 1;

  // highest set bit wins; zero input reports W
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (x_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/div_norm.sv
module div_norm #(
  parameter int W = 32
) (
  input  logic [W-1:0]       x_i,
  output logic [W-1:0]       norm_o,
  output logic [$clog2(W):0] lz_o
);
  localparam int CW = $clog2(W) + 1;

  div_lzc #(.W(W)) u_lzc (
    .x_i  (x_i),
    .cnt_o(lz_o)
  );

  assign norm_o = x_i << lz_o;

  always_comb begin
    if (x_i != '0) begin
      // R2
      norm_msb_chk: assert (norm_o[W-1]);
    end else begin
      // R6
      lz_zero_chk: assert (lz_o == CW'(W));
    end
  end
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int W = 32
) (
  input  logic [W:0]   rem_i,
  input  logic [W-1:0] div_i,
  output logic         bit_o,
  output logic [W:0]   rem_o
);
  assign bit_o = (rem_i >= {1'b0, div_i});
  assign rem_o = bit_o ? (rem_i - {1'b0, div_i}) : rem_i;
endmodule

// File: rtl/norm_div.sv
module norm_div
  import norm_div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         dbz_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W) + 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  div_state_e state_q;
  logic [W:0]    rem_r;
  logic [W-1:0]  div_r, q_r, hold_r, a_r;
  logic [CW-1:0] cnt_r, m_r, lzb_r;
  logic          neg_r;

  logic [W-1:0]   a_norm, b_norm;
  logic [CW-1:0]  lz_a, lz_b;
  logic signed [CW:0] m_s;

  div_norm #(.W(W)) u_norm_a (.x_i(dividend_i), .norm_o(a_norm), .lz_o(lz_a));
  div_norm #(.W(W)) u_norm_b (.x_i(divisor_i),  .norm_o(b_norm), .lz_o(lz_b));

  // alignment between operands; negative means dividend < divisor
  assign m_s = $signed({1'b0, lz_b}) - $signed({1'b0, lz_a});

  logic         q_bit;
  logic [W:0]   rem_nx;
  logic [W-1:0] q_nx, hold_nx;

  div_step #(.W(W)) u_step (
    .rem_i(rem_r),
    .div_i(div_r),
    .bit_o(q_bit),
    .rem_o(rem_nx)
  );

  assign q_nx    = {q_r[W-2:0], q_bit};
  // partial remainder at step m is the scaled integer remainder
  assign hold_nx = (cnt_r == m_r) ? rem_nx[W-1:0] : hold_r;
  assign busy_o  = (state_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_r   <= '0;
      div_r   <= '0;
      q_r     <= '0;
      hold_r  <= '0;
      a_r     <= '0;
      cnt_r   <= '0;
      m_r     <= '0;
      lzb_r   <= '0;
      neg_r   <= 1'b0;
      done_o  <= 1'b0;
      dbz_o   <= 1'b0;
      quo_o   <= '0;
      rem_o   <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (divisor_i == '0) begin
              done_o <= 1'b1;
              dbz_o  <= 1'b1;
              quo_o  <= '1;
              rem_o  <= dividend_i;
            end else begin
              rem_r   <= {1'b0, a_norm};
              div_r   <= b_norm;
              q_r     <= '0;
              hold_r  <= '0;
              a_r     <= dividend_i;
              cnt_r   <= '0;
              m_r     <= m_s[CW-1:0];
              neg_r   <= m_s[CW];
              lzb_r   <= lz_b;
              state_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          rem_r  <= {rem_nx[W-1:0], 1'b0};
          q_r    <= q_nx;
          hold_r <= hold_nx;
          cnt_r  <= cnt_r + 1'b1;
          if (cnt_r == LAST) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
            dbz_o   <= 1'b0;
            quo_o   <= neg_r ? '0  : (q_nx >> (LAST - m_r));
            rem_o   <= neg_r ? a_r : (hold_nx >> lzb_r);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // checker state: cycles since accepted start, divisor captured at start
  logic [CW:0]  lat_q;
  logic [W-1:0] b_chk;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      b_chk <= '0;
    end else if (!busy_o && start_i && divisor_i != '0) begin
      lat_q <= (CW+1)'(1);
      b_chk <= divisor_i;
    end else if (busy_o) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  // R4
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !dbz_o) |-> (lat_q == (CW+1)'(W + 1)));
  // R4
  done_no_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R3
  rem_below_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !dbz_o) |-> (rem_o < b_chk));
  // R5
  dbz_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbz_o |-> (quo_o == '1));
  // R7
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_r != LAST) |=> busy_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !(start_i && divisor_i == '0)) |=> !done_o);
endmodule

// File: tb/tb_norm_div.sv
module tb_norm_div;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         start_i;
  logic [W-1:0] dividend_i, divisor_i;
  logic         busy_o, done_o, dbz_o;
  logic [W-1:0] quo_o, rem_o;

  int n_checks = 0;
  int n_errors = 0;

  norm_div #(.W(W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o), .dbz_o(dbz_o),
    .quo_o(quo_o), .rem_o(rem_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_div(input int a, input int b);
    int cyc;
    int exp_q, exp_r, exp_lat;
    bit busy_ok;
    string tag;
    exp_q   = (b == 0) ? (1 << W) - 1 : a / b;
    exp_r   = (b == 0) ? a : a % b;
    exp_lat = (b == 0) ? 1 : W + 1;
    tag     = (b == 0) ? "R5" : ((a < b) ? "R6" : "R2");
    @(negedge clk_i);
    start_i    = 1'b1;
    dividend_i = W'(a);
    divisor_i  = W'(b);
    @(negedge clk_i);
    start_i = 1'b0;
    cyc     = 1;
    busy_ok = 1'b1;
    while (!done_o && cyc < 100) begin
      if (!busy_o) busy_ok = 1'b0;
      @(negedge clk_i);
      cyc++;
    end
    chk(quo_o == W'(exp_q), tag, "quotient", int'(quo_o), exp_q);
    chk(rem_o == W'(exp_r), tag, "remainder", int'(rem_o), exp_r);
    chk(dbz_o == (b == 0), (b == 0) ? "R5" : "R2", "dbz flag", int'(dbz_o), int'(b == 0));
    chk(cyc == exp_lat, (b == 0) ? "R5" : "R4", "latency", cyc, exp_lat);
    chk(busy_ok && !busy_o, "R4", "busy during run / low at done", int'(busy_ok), 1);
    if (b != 0) chk(int'(rem_o) < b, "R3", "remainder below divisor", int'(rem_o), b);
  endtask

  initial begin
    #(8 * 200000);
    n_errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int q_hold, r_hold, cyc;
    rst_ni     = 1'b0;
    start_i    = 1'b0;
    dividend_i = '0;
    divisor_i  = '0;
    repeat (3) @(negedge clk_i);
    // R1
    chk(!busy_o && !done_o && !dbz_o, "R1", "reset flags", int'({busy_o, done_o, dbz_o}), 0);
    chk(quo_o == '0 && rem_o == '0, "R1", "reset data", int'({quo_o, rem_o}), 0);
    rst_ni = 1'b1;

    run_div(200, 3);
    run_div(77, 0);     // R5
    run_div(100, 10);   // R8 dbz cleared
    run_div(5, 9);      // R6
    run_div(0, 7);      // R6 zero dividend
    run_div(255, 1);
    run_div(255, 255);
    run_div(128, 128);

    // R8: held after done
    q_hold = int'(quo_o);
    r_hold = int'(rem_o);
    repeat (3) @(negedge clk_i);
    chk(!done_o, "R8", "done single pulse", int'(done_o), 0);
    chk(int'(quo_o) == q_hold && int'(rem_o) == r_hold, "R8", "results held",
        int'(quo_o), q_hold);

    // R7: start while busy ignored
    @(negedge clk_i);
    start_i = 1'b1; dividend_i = 8'd200; divisor_i = 8'd7;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (2) @(negedge clk_i);
    start_i = 1'b1; dividend_i = 8'd13; divisor_i = 8'd0;
    @(negedge clk_i);
    start_i = 1'b0; dividend_i = 8'd99; divisor_i = 8'd2;
    cyc = 4;
    while (!done_o && cyc < 100) begin
      @(negedge clk_i);
      cyc++;
    end
    chk(quo_o == 8'd28 && rem_o == 8'd4, "R7", "result of first operands",
        int'(quo_o), 28);
    chk(!dbz_o, "R7", "ignored zero-divisor start", int'(dbz_o), 0);
    chk(cyc == W + 1, "R7", "latency unchanged", cyc, W + 1);

    // near-exhaustive sweep
    for (int b = 0; b < 256; b++) begin
      for (int a = 0; a < 256; a += 9) run_div(a, b);
      run_div(255, b);
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule